// File: doc/BRIEF.md
# CPU Standby and Restart Controller

This block decides whether the CPU of a small 8-bit microcontroller is clocked. It also supplies the program-memory word address from which the CPU loads its start address after a system reset. Software enters the low-power halt state by writing 1 to a single halt control bit. From the next rising edge of the system clock the CPU clock stays low, while the system clock and every peripheral keep running.

The halt ends when one of three things arrives: a non-maskable interrupt request, a watchdog interrupt request, or a maskable interrupt request whose enable bit is set. The halt bit is released on the falling edge of the system clock in the cycle where that request is present. The CPU clock then resumes with the following rising edge. All gating decisions are taken on the falling edge, so the gated clock never produces a shortened pulse.

The block records the cause of every reset. Power-on, the external reset pin, loss of the low-speed oscillator and watchdog overflow all restart the CPU from the vector pair at words 0x0002/0x0003. A software break restarts from the pair at 0x0004/0x0005. The exception is a break taken while the interrupt nesting level is 2 or more: it falls back to 0x0002/0x0003.

Top module: `cpu_standby_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, and from that edge on, `halt_o` is 0, `vec_addr` is 0x0002 and `cpu_clk` follows `clk_sys`.
- R2: A write (`ctl_wr`=1, `ctl_halt_wdata`=1) sets `halt_o` from the next rising edge of `clk_sys`. From that edge until a wake-up, `cpu_clk` has no rising edge.
- R3: A write with `ctl_halt_wdata`=0 leaves `halt_o` at 0 and the CPU clock running.
- R4: While halted, `nmi_req` or `wdt_irq` drops `halt_o` at the falling edge of the cycle in which the request is present. `cpu_clk` rises again at the next rising edge.
- R5: A maskable request `irq_req[i]` wakes the block only when `irq_en[i]` is 1. With `irq_en[i]` at 0 the block stays halted and `cpu_clk` stays low. Request bits are grouped by eight per enable register, and every one of the 56 bits can wake the block.
- R6: A wake-up request present in the same cycle as a halt write cancels the halt. `halt_o` never reads 1 at a rising edge, and `cpu_clk` keeps toggling.
- R7: Every reset source (external pin, oscillator loss, watchdog overflow, break) clears `halt_o` at the next rising edge. `cpu_clk` restarts at that edge.
- R8: `ext_rst_n`=0, `osc_lost_rst`=1 or `wdt_ovf_rst`=1 at a rising edge sets `vec_addr` to 0x0002 from that edge on.
- R9: `brk_req`=1 sets `vec_addr` to 0x0004 when `int_level` is 0 or 1, and to 0x0002 when `int_level` is 2 or 3.
- R10: A hardware reset source and a break in the same cycle select 0x0002.
- R11: `vec_addr` holds its value in every cycle without a reset event. Interrupt level changes, wake-up requests and writes have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock; peripherals run from it |
| rst_n | input | 1 | Power-on reset, active low, synchronous |
| ext_rst_n | input | 1 | External reset pin request, active low, already synchronised |
| osc_lost_rst | input | 1 | Low-speed oscillator stop detected, reset request |
| wdt_ovf_rst | input | 1 | Watchdog overflow reset request |
| brk_req | input | 1 | Software break reset request |
| int_level | input | 2 | Current interrupt nesting level from the status word |
| nmi_req | input | 1 | Non-maskable interrupt request |
| wdt_irq | input | 1 | Watchdog interrupt request |
| irq_req | input | 56 | Maskable interrupt requests, 7 groups of 8 |
| irq_en | input | 56 | Enable bit for each maskable request |
| ctl_wr | input | 1 | Write strobe for the standby control register |
| ctl_halt_wdata | input | 1 | Value written to the halt bit |
| cpu_clk | output | 1 | Gated CPU clock, low while halted |
| halt_o | output | 1 | Halt state |
| vec_addr | output | 16 | Word address of the first word of the selected vector pair |

## Verification
Stimulus changes one nanosecond after a rising edge. Each expected value is queued for an exact cycle and phase. The effects of writes and reset sources are due in the high phase after the next rising edge. A wake-up is due in the low phase of the same cycle, because it acts on the falling edge. The clock restart shows up as a single extra `cpu_clk` rising edge in the high phase of the following cycle. The monitor compares each item only in its own slot, once in the high phase and once in the low phase of every cycle. An item that is never reached is counted as a miscompare.

// File: rtl/stby_pkg.sv
`timescale 1ns/1ps
// Shared types for the standby and restart controller.
// Assumes: nothing beyond SystemVerilog packages.
package stby_pkg;

    // Recorded cause of the last system reset.
    typedef enum logic [2:0] {
        CAUSE_POWER_ON   = 3'd0,
        CAUSE_EXT_PIN    = 3'd1,
        CAUSE_OSC_LOST   = 3'd2,
        CAUSE_WDT_OVF    = 3'd3,
        CAUSE_BRK_PLAIN  = 3'd4,
        CAUSE_BRK_NESTED = 3'd5
    } rst_cause_e;

    // True when the cause restarts the CPU from the break vector pair.
    function automatic logic uses_brk_pair(rst_cause_e c);
        return (c == CAUSE_BRK_PLAIN);
    endfunction

endpackage

// File: rtl/stby_wake_detect.sv
`timescale 1ns/1ps
// Wake-up detector: merges the non-maskable, watchdog and enabled
// maskable requests into a single level. Purely combinational.
// Assumes: requests are synchronous to clk_sys and held as levels.
module stby_wake_detect #(
    parameter int NUM_GRP = 7,
    parameter int GRP_W   = 8
) (
    input  logic                       nmi_req,
    input  logic                       wdt_irq,
    input  logic [NUM_GRP*GRP_W-1:0]   irq_req,
    input  logic [NUM_GRP*GRP_W-1:0]   irq_en,
    output logic                       wake
);
    logic [NUM_GRP-1:0] grp_hit;

    // One enabled-request reduction per interrupt-enable group.
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        assign grp_hit[g] = |(irq_req[g*GRP_W +: GRP_W] & irq_en[g*GRP_W +: GRP_W]);
    end

    // Any source ends the halt.
    assign wake = nmi_req | wdt_irq | (|grp_hit);

endmodule

// File: rtl/stby_reset_cause.sv
`timescale 1ns/1ps
// Reset cause recorder and restart vector selector.
// Hardware sources outrank a break. A break taken at an interrupt level
// of ESC_LEVEL or more falls back to the hardware vector pair.
// Assumes: every reset request is synchronous to clk_sys and lasts at
// least one cycle; rst_n is the power-on reset.
module stby_reset_cause
    import stby_pkg::*;
#(
    parameter int              LVL_W     = 2,
    parameter int              ESC_LEVEL = 2,
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] HW_VEC  = 16'h0002,
    parameter logic [ADDR_W-1:0] BRK_VEC = 16'h0004
) (
    input  logic              clk_sys,
    input  logic              rst_n,
    input  logic              ext_rst_n,
    input  logic              osc_lost_rst,
    input  logic              wdt_ovf_rst,
    input  logic              brk_req,
    input  logic [LVL_W-1:0]  int_level,
    output logic              sys_rst_n,
    output logic [ADDR_W-1:0] vec_addr
);
    localparam logic [LVL_W-1:0] ESC_LVL = LVL_W'(ESC_LEVEL);

    rst_cause_e cause_q;
    rst_cause_e cause_d;
    logic       hw_evt;

    // Hardware reset sources other than power-on.
    assign hw_evt    = !ext_rst_n | osc_lost_rst | wdt_ovf_rst;
    // Combined active-low system reset seen by the rest of the block.
    assign sys_rst_n = rst_n & !hw_evt & !brk_req;

    // Next cause: priority power-on, pin, oscillator, watchdog, break.
    always_comb begin
        cause_d = cause_q;
        if (!ext_rst_n)
            cause_d = CAUSE_EXT_PIN;
        else if (osc_lost_rst)
            cause_d = CAUSE_OSC_LOST;
        else if (wdt_ovf_rst)
            cause_d = CAUSE_WDT_OVF;
        else if (brk_req)
            cause_d = (int_level >= ESC_LVL) ? CAUSE_BRK_NESTED : CAUSE_BRK_PLAIN;
    end

    // Cause register; held between reset events.
    always_ff @(posedge clk_sys) begin
        if (!rst_n)
            cause_q <= CAUSE_POWER_ON;
        else
            cause_q <= cause_d;
    end

    // Vector pair address from the recorded cause.
    assign vec_addr = uses_brk_pair(cause_q) ? BRK_VEC : HW_VEC;

endmodule

// File: rtl/stby_halt_ctrl.sv
`timescale 1ns/1ps
// Halt bit with falling-edge release.
// halt_set_q is set on the rising edge after a halt write. wake_seen_q
// samples a wake-up on the falling edge when a halt is active or about
// to become active, which immediately masks halt_o. The next rising
// edge then clears halt_set_q, which outranks a write landing there.
// Assumes: sys_rst_n is synchronous to clk_sys.
module stby_halt_ctrl (
    input  logic clk_sys,
    input  logic sys_rst_n,
    input  logic wr_set,
    input  logic wake,
    output logic halt_o,
    output logic clk_en_d
);
    logic halt_set_q;
    logic wake_seen_q;
    logic pending;

    // Halt is in force, or a halt write lands at the next rising edge.
    assign pending = halt_set_q | wr_set;

    // Halt bit: reset clears, a seen wake-up clears, a write sets.
    always_ff @(posedge clk_sys) begin
        if (!sys_rst_n)
            halt_set_q <= 1'b0;
        else if (wake_seen_q)
            halt_set_q <= 1'b0;
        else if (wr_set)
            halt_set_q <= 1'b1;
    end

    // Falling-edge capture of a wake-up that applies to a halt.
    always_ff @(negedge clk_sys) begin
        if (!sys_rst_n)
            wake_seen_q <= 1'b0;
        else
            wake_seen_q <= wake & pending;
    end

    // Visible halt state.
    assign halt_o   = halt_set_q & !wake_seen_q;
    // Clock enable to be sampled on the falling edge.
    assign clk_en_d = !(pending & !wake);

endmodule

// File: rtl/stby_clk_gate.sv
`timescale 1ns/1ps
// Glitch-free CPU clock gate. The enable is registered on the falling
// edge, so it only changes while clk_sys is low, and it is ANDed with
// the clock. Reset forces the clock to run.
// Assumes: en_d is stable around the falling edge of clk_sys.
module stby_clk_gate (
    input  logic clk_sys,
    input  logic sys_rst_n,
    input  logic en_d,
    output logic gate_en,
    output logic cpu_clk
);
    // Enable register, updated only while the clock is low.
    always_ff @(negedge clk_sys) begin
        if (!sys_rst_n)
            gate_en <= 1'b1;
        else
            gate_en <= en_d;
    end

    // Gated clock output.
    assign cpu_clk = clk_sys & gate_en;

endmodule

// File: rtl/cpu_standby_ctrl.sv
`timescale 1ns/1ps
// CPU standby and restart controller, top level.
// Joins wake-up detection, the halt bit, the CPU clock gate and the
// reset-cause vector selector.
// Assumes: all inputs are synchronous to clk_sys; the CPU cannot write
// while halted because its clock is stopped.
module cpu_standby_ctrl #(
    parameter int                NUM_IE_REGS = 7,
    parameter int                IE_BITS     = 8,
    parameter int                LVL_W       = 2,
    parameter int                ESC_LEVEL   = 2,
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] HW_VEC      = 16'h0002,
    parameter logic [ADDR_W-1:0] BRK_VEC     = 16'h0004,
    localparam int               NIRQ        = NUM_IE_REGS * IE_BITS
) (
    input  logic              clk_sys,
    input  logic              rst_n,
    input  logic              ext_rst_n,
    input  logic              osc_lost_rst,
    input  logic              wdt_ovf_rst,
    input  logic              brk_req,
    input  logic [LVL_W-1:0]  int_level,
    input  logic              nmi_req,
    input  logic              wdt_irq,
    input  logic [NIRQ-1:0]   irq_req,
    input  logic [NIRQ-1:0]   irq_en,
    input  logic              ctl_wr,
    input  logic              ctl_halt_wdata,
    output logic              cpu_clk,
    output logic              halt_o,
    output logic [ADDR_W-1:0] vec_addr
);
    logic sys_rst_n;
    logic wake;
    logic wr_set;
    logic clk_en_d;
    logic gate_en;

    // Write that sets the halt bit.
    assign wr_set = ctl_wr & ctl_halt_wdata;

    stby_reset_cause #(
        .LVL_W     (LVL_W),
        .ESC_LEVEL (ESC_LEVEL),
        .ADDR_W    (ADDR_W),
        .HW_VEC    (HW_VEC),
        .BRK_VEC   (BRK_VEC)
    ) cause_i (
        .clk_sys      (clk_sys),
        .rst_n        (rst_n),
        .ext_rst_n    (ext_rst_n),
        .osc_lost_rst (osc_lost_rst),
        .wdt_ovf_rst  (wdt_ovf_rst),
        .brk_req      (brk_req),
        .int_level    (int_level),
        .sys_rst_n    (sys_rst_n),
        .vec_addr     (vec_addr)
    );

    stby_wake_detect #(
        .NUM_GRP (NUM_IE_REGS),
        .GRP_W   (IE_BITS)
    ) wake_i (
        .nmi_req (nmi_req),
        .wdt_irq (wdt_irq),
        .irq_req (irq_req),
        .irq_en  (irq_en),
        .wake    (wake)
    );

    stby_halt_ctrl halt_i (
        .clk_sys   (clk_sys),
        .sys_rst_n (sys_rst_n),
        .wr_set    (wr_set),
        .wake      (wake),
        .halt_o    (halt_o),
        .clk_en_d  (clk_en_d)
    );

    stby_clk_gate gate_i (
        .clk_sys   (clk_sys),
        .sys_rst_n (sys_rst_n),
        .en_d      (clk_en_d),
        .gate_en   (gate_en),
        .cpu_clk   (cpu_clk)
    );

endmodule

// File: rtl/cpu_standby_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for cpu_standby_ctrl, attached with bind.
// Assumes: the same parameter values as the bound instance.
module cpu_standby_ctrl_chk #(
    parameter int                LVL_W     = 2,
    parameter int                ESC_LEVEL = 2,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] HW_VEC    = 16'h0002,
    parameter logic [ADDR_W-1:0] BRK_VEC   = 16'h0004
) (
    input logic              clk_sys,
    input logic              rst_n,
    input logic              sys_rst_n,
    input logic              ext_rst_n,
    input logic              osc_lost_rst,
    input logic              wdt_ovf_rst,
    input logic              brk_req,
    input logic [LVL_W-1:0]  int_level,
    input logic              nmi_req,
    input logic              wdt_irq,
    input logic              wake,
    input logic              wr_set,
    input logic              gate_en,
    input logic              halt_o,
    input logic [ADDR_W-1:0] vec_addr
);
    localparam logic [LVL_W-1:0] ESC_LVL = LVL_W'(ESC_LEVEL);

    // R2: a halted CPU never has its clock enabled outside reset.
    assert_gate_off_when_halted_R2: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (halt_o && sys_rst_n) |-> !gate_en);

    // R4: a non-maskable or watchdog request ends the halt at this falling edge.
    assert_wake_release_R4: assert property (@(negedge clk_sys) disable iff (!rst_n)
        (halt_o && (nmi_req || wdt_irq)) |=> !halt_o);

    // R6: a wake-up together with a halt write leaves no halt behind.
    assert_cancel_same_cycle_R6: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (wr_set && wake) |=> !halt_o);

    // R7: every reset source clears the halt.
    assert_reset_clears_halt_R7: assert property (@(posedge clk_sys) disable iff (!rst_n)
        !sys_rst_n |=> !halt_o);

    // R8: hardware reset sources select the hardware vector pair.
    assert_hw_vector_R8: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (!ext_rst_n || osc_lost_rst || wdt_ovf_rst) |=> (vec_addr == HW_VEC));

    // R9: a plain break selects the break vector pair.
    assert_brk_vector_R9: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (brk_req && ext_rst_n && !osc_lost_rst && !wdt_ovf_rst && (int_level < ESC_LVL))
        |=> (vec_addr == BRK_VEC));

    // R11: without a reset event the vector address does not move.
    assert_vec_hold_R11: assert property (@(posedge clk_sys) disable iff (!rst_n)
        sys_rst_n |=> $stable(vec_addr));

endmodule

bind cpu_standby_ctrl cpu_standby_ctrl_chk #(
    .LVL_W     (LVL_W),
    .ESC_LEVEL (ESC_LEVEL),
    .ADDR_W    (ADDR_W),
    .HW_VEC    (HW_VEC),
    .BRK_VEC   (BRK_VEC)
) chk_i (
    .clk_sys      (clk_sys),
    .rst_n        (rst_n),
    .sys_rst_n    (sys_rst_n),
    .ext_rst_n    (ext_rst_n),
    .osc_lost_rst (osc_lost_rst),
    .wdt_ovf_rst  (wdt_ovf_rst),
    .brk_req      (brk_req),
    .int_level    (int_level),
    .nmi_req      (nmi_req),
    .wdt_irq      (wdt_irq),
    .wake         (wake),
    .wr_set       (wr_set),
    .gate_en      (gate_en),
    .halt_o       (halt_o),
    .vec_addr     (vec_addr)
);

// File: tb/cpu_standby_ctrl_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench for cpu_standby_ctrl. Driver tasks queue expected
// values tagged with cycle and phase; the monitor compares them.
module cpu_standby_ctrl_tb_top;
    localparam int NIRQ = 56;
    localparam int K_HALT = 0, K_VEC = 1, K_PULSE = 2;

    logic        clk_sys = 1'b0;
    logic        rst_n = 1'b0, ext_rst_n = 1'b1, osc_lost_rst = 1'b0, wdt_ovf_rst = 1'b0;
    logic        brk_req = 1'b0, nmi_req = 1'b0, wdt_irq = 1'b0;
    logic [1:0]  int_level = 2'd0;
    logic [NIRQ-1:0] irq_req = '0, irq_en = '0;
    logic        ctl_wr = 1'b0, ctl_halt_wdata = 1'b0;
    logic        cpu_clk, halt_o;
    logic [15:0] vec_addr;

    always #2 clk_sys = ~clk_sys;   // 250 MHz

    cpu_standby_ctrl dut_i (
        .clk_sys(clk_sys), .rst_n(rst_n), .ext_rst_n(ext_rst_n),
        .osc_lost_rst(osc_lost_rst), .wdt_ovf_rst(wdt_ovf_rst), .brk_req(brk_req),
        .int_level(int_level), .nmi_req(nmi_req), .wdt_irq(wdt_irq),
        .irq_req(irq_req), .irq_en(irq_en), .ctl_wr(ctl_wr),
        .ctl_halt_wdata(ctl_halt_wdata), .cpu_clk(cpu_clk), .halt_o(halt_o),
        .vec_addr(vec_addr)
    );

    int cyc = 0;
    int cpu_rises = 0;
    int mark = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit ended = 1'b0;

    always @(posedge clk_sys) cyc <= cyc + 1;
    always @(posedge cpu_clk) cpu_rises <= cpu_rises + 1;

    typedef struct {
        int    due;
        bit    lo;
        int    kind;
        int    exp;
        string req;
    } exp_t;
    exp_t sb[$];

    // Insert keeping the queue ordered by cycle, then phase.
    task automatic expect_at(int due, bit lo, int kind, int exp, string req);
        exp_t it;
        int pos;
        it = '{due, lo, kind, exp, req};
        pos = sb.size();
        for (int i = 0; i < sb.size(); i++) begin
            if ((sb[i].due * 2 + int'(sb[i].lo)) > (due * 2 + int'(lo))) begin
                pos = i;
                break;
            end
        end
        sb.insert(pos, it);
    endtask

    function automatic int observe(int kind);
        case (kind)
            K_HALT:  return (halt_o === 1'b1) ? 1 : ((halt_o === 1'b0) ? 0 : -1);
            K_VEC:   return int'(vec_addr);
            default: return cpu_rises - mark;
        endcase
    endfunction

    task automatic compare(bit lo);
        exp_t it;
        int act;
        while (sb.size() > 0 && sb[0].due == cyc && sb[0].lo == lo) begin
            it = sb.pop_front();
            act = observe(it.kind);
            n_checks++;
            if (act != it.exp) begin
                n_fail++;
                $display("FAIL %s: kind %0d cycle %0d phase %0d actual %0h expected %0h",
                         it.req, it.kind, cyc, it.lo, act, it.exp);
            end
        end
    endtask

    // Monitor: high phase at +1 ns, low phase at +3 ns after each rise.
    initial begin
        forever begin
            @(posedge clk_sys);
            #1;
            compare(1'b0);
            #2;
            compare(1'b1);
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk_sys);
        n_fail++;
        $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
        finish_run();
    end

    task automatic tick();
        @(posedge clk_sys);
        #1;
    endtask

    // Halt write and the checks that follow it (R2).
    task automatic enter_halt();
        int c;
        c = cyc;
        ctl_wr = 1'b1;
        ctl_halt_wdata = 1'b1;
        mark = cpu_rises;
        expect_at(c + 1, 1'b0, K_HALT, 1, "R2");
        expect_at(c + 3, 1'b0, K_HALT, 1, "R2");
        expect_at(c + 3, 1'b0, K_PULSE, 0, "R2");
        tick();
        ctl_wr = 1'b0;
        ctl_halt_wdata = 1'b0;
        repeat (3) tick();
    endtask

    // One-cycle reset source: 0 pin, 1 osc, 2 wdt overflow, 3 break, 4 pin+break, 5 power-on.
    task automatic pulse_reset(int src, logic [1:0] lvl, int exp_vec, string req);
        int c;
        c = cyc;
        int_level = lvl;
        case (src)
            0: ext_rst_n = 1'b0;
            1: osc_lost_rst = 1'b1;
            2: wdt_ovf_rst = 1'b1;
            3: brk_req = 1'b1;
            4: begin ext_rst_n = 1'b0; brk_req = 1'b1; end
            default: rst_n = 1'b0;
        endcase
        expect_at(c + 1, 1'b0, K_VEC, exp_vec, req);
        tick();
        ext_rst_n = 1'b1; osc_lost_rst = 1'b0; wdt_ovf_rst = 1'b0;
        brk_req = 1'b0; rst_n = 1'b1; int_level = 2'd0;
        tick();
    endtask

    initial begin
        int c;
        repeat (3) tick();
        // R1: reset state and running CPU clock.
        c = cyc;
        rst_n = 1'b1;
        mark = cpu_rises;
        expect_at(c + 1, 1'b0, K_HALT, 0, "R1");
        expect_at(c + 1, 1'b0, K_VEC, 16'h0002, "R1");
        expect_at(c + 3, 1'b0, K_PULSE, 3, "R1");
        repeat (4) tick();

        // R3: writing 0 to the halt bit changes nothing.
        c = cyc;
        ctl_wr = 1'b1; ctl_halt_wdata = 1'b0;
        mark = cpu_rises;
        expect_at(c + 1, 1'b0, K_HALT, 0, "R3");
        expect_at(c + 2, 1'b0, K_PULSE, 2, "R3");
        tick();
        ctl_wr = 1'b0;
        repeat (2) tick();

        // R2 + R4: halt, then wake by non-maskable request.
        enter_halt();
        c = cyc;
        nmi_req = 1'b1;
        expect_at(c, 1'b1, K_HALT, 0, "R4");
        expect_at(c + 1, 1'b0, K_PULSE, 1, "R4");
        tick();
        nmi_req = 1'b0;
        tick();

        // R4: wake by watchdog interrupt.
        enter_halt();
        c = cyc;
        wdt_irq = 1'b1;
        expect_at(c, 1'b1, K_HALT, 0, "R4");
        expect_at(c + 1, 1'b0, K_PULSE, 1, "R4");
        tick();
        wdt_irq = 1'b0;
        tick();

        // R5: masked request keeps the halt, enabled top bit ends it.
        irq_en = '0;
        irq_en[10] = 1'b1;
        irq_en[NIRQ-1] = 1'b1;
        enter_halt();
        c = cyc;
        irq_req[3] = 1'b1;
        expect_at(c, 1'b1, K_HALT, 1, "R5");
        expect_at(c + 1, 1'b0, K_HALT, 1, "R5");
        expect_at(c + 2, 1'b0, K_PULSE, 0, "R5");
        tick();
        tick();
        c = cyc;
        irq_req[3] = 1'b0;
        irq_req[NIRQ-1] = 1'b1;
        expect_at(c, 1'b1, K_HALT, 0, "R5");
        expect_at(c + 1, 1'b0, K_PULSE, 1, "R5");
        tick();
        irq_req[NIRQ-1] = 1'b0;
        tick();

        // R6: wake-up in the cycle of the halt write cancels it.
        c = cyc;
        ctl_wr = 1'b1; ctl_halt_wdata = 1'b1; irq_req[10] = 1'b1;
        mark = cpu_rises;
        expect_at(c + 1, 1'b0, K_HALT, 0, "R6");
        expect_at(c + 1, 1'b1, K_HALT, 0, "R6");
        expect_at(c + 3, 1'b0, K_PULSE, 3, "R6");
        tick();
        ctl_wr = 1'b0; ctl_halt_wdata = 1'b0; irq_req[10] = 1'b0;
        repeat (3) tick();

        // R9: plain break, then R7 + R8: watchdog overflow during halt.
        pulse_reset(3, 2'd0, 16'h0004, "R9");
        enter_halt();
        c = cyc;
        wdt_ovf_rst = 1'b1;
        expect_at(c + 1, 1'b0, K_HALT, 0, "R7");
        expect_at(c + 1, 1'b0, K_VEC, 16'h0002, "R8");
        expect_at(c + 1, 1'b0, K_PULSE, 1, "R7");
        tick();
        wdt_ovf_rst = 1'b0;
        tick();

        // R7: break during halt also clears it.
        enter_halt();
        c = cyc;
        brk_req = 1'b1;
        expect_at(c + 1, 1'b0, K_HALT, 0, "R7");
        expect_at(c + 1, 1'b0, K_VEC, 16'h0004, "R9");
        tick();
        brk_req = 1'b0;
        tick();

        // R8 / R9 across sources and levels.
        pulse_reset(0, 2'd0, 16'h0002, "R8");
        pulse_reset(3, 2'd1, 16'h0004, "R9");
        pulse_reset(1, 2'd0, 16'h0002, "R8");
        pulse_reset(3, 2'd0, 16'h0004, "R9");
        pulse_reset(3, 2'd2, 16'h0002, "R9");
        pulse_reset(3, 2'd1, 16'h0004, "R9");
        pulse_reset(3, 2'd3, 16'h0002, "R9");
        pulse_reset(3, 2'd0, 16'h0004, "R9");
        pulse_reset(2, 2'd0, 16'h0002, "R8");

        // R10: hardware reset and break together.
        pulse_reset(3, 2'd0, 16'h0004, "R9");
        pulse_reset(4, 2'd0, 16'h0002, "R10");

        // R11: vector holds while other inputs move.
        pulse_reset(3, 2'd1, 16'h0004, "R9");
        for (int k = 0; k < 6; k++) begin
            c = cyc;
            int_level = 2'(k);
            nmi_req = k[0];
            irq_req[10] = k[1];
            ctl_wr = k[0];
            ctl_halt_wdata = 1'b0;
            expect_at(c + 1, 1'b0, K_VEC, 16'h0004, "R11");
            tick();
        end
        nmi_req = 1'b0; irq_req[10] = 1'b0; ctl_wr = 1'b0; int_level = 2'd0;
        tick();

        // R1: power-on reset during halt.
        enter_halt();
        c = cyc;
        rst_n = 1'b0;
        expect_at(c + 1, 1'b0, K_HALT, 0, "R1");
        expect_at(c + 1, 1'b0, K_VEC, 16'h0002, "R1");
        tick();
        rst_n = 1'b1;
        repeat (3) tick();

        if (sb.size() != 0) begin
            n_fail += sb.size();
            $display("FAIL scoreboard: actual %0d pending items expected 0", sb.size());
        end
        finish_run();
    end

endmodule